// File: doc/BRIEF.md
# Split L1 Cross-Snoop Coherency Controller

This block keeps a split level-one instruction cache and data cache coherent. It does this by snooping the sibling cache whenever one of them misses. When an instruction fetch misses, the controller probes the data-cache tags for the same 32-byte line. A dirty copy found there is written back first. The writeback goes into the level-two cache when L2 holds the line, and otherwise goes out as a system-bus write. The data line is then invalidated, and the instruction fill is sourced from L2 or from the bus. When a data read or write misses, the controller probes the instruction-cache tags and drops a matching line without any writeback. It then releases the data access so that it proceeds normally.

The controller services one miss at a time. Its `busy` output tells both requesters to hold their requests until the sequence returns to idle. All tag probes, invalidates, L2 lookups and bus requests carry a single line address. That address is the captured miss address with the offset bits removed, because both L1 caches use the same line size and set-index function. The tag arrays and L2 answer probes combinationally in the cycle the probe strobe is high. Bus requests are held until they are acknowledged.

Top module: `l1_xsnoop_ctrl`

## Requirements
- R1: A miss request is accepted only on a clock edge where `busy` is low. After an instruction miss is accepted, `dc_probe_vld` is high for exactly one cycle, in the next cycle, with `line_addr` equal to the miss address bits [31:5].
- R2: An accepted data miss, read or write, raises `ic_probe_vld` for exactly one cycle with `line_addr` equal to the miss address bits [31:5]. It causes no data-cache probe.
- R3: L2 is never looked up in a cycle where either tag probe is high. L2 is used only for a dirty writeback or an instruction fill, and never during a data-miss sequence.
- R4: A data-probe hit on a dirty line raises `l2_wb_vld` for one cycle. If `l2_wb_hit` is high in that cycle, L2 keeps the line and no bus write follows.
- R5: If the L2 writeback misses, `bus_wr_vld` rises in the next cycle and stays high up to and including the cycle `bus_wr_ack` is high.
- R6: Any data-probe hit, clean or dirty, produces exactly one `dc_inval_vld` cycle after any writeback has finished. A data-probe miss produces none.
- R7: An instruction fill first raises `l2_rd_vld`. If `l2_rd_hit` is high, `ic_fill_done` pulses in that cycle with `ic_fill_from_l2`=1. Otherwise `bus_rd_vld` is held until `bus_rd_ack`, and `ic_fill_done` pulses in the ack cycle with `ic_fill_from_l2`=0.
- R8: An instruction-probe hit gives exactly one `ic_inval_vld` cycle and no writeback. `dc_proceed` pulses once per data miss, with `dc_proceed_wr` equal to the write flag of the miss, and also pulses in the invalidate cycle.
- R9: While `busy` is high, new requests are ignored and the captured line stays stable. When both requests arrive on the same edge, the instruction miss is served first, and the still-held data miss is served afterwards.
- R10: A probe miss adds no cycles beyond the probe. An instruction sequence enters the L2 fill in the next cycle. A data sequence pulses `dc_proceed` in the probe cycle itself.
- R11: While reset is asserted, and right after it asserts in the middle of a sequence, `busy` and every strobe output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ic_miss_req | input | 1 | Instruction-cache read miss request |
| ic_miss_addr | input | 32 | Byte address of the instruction miss |
| dc_miss_req | input | 1 | Data-cache miss request |
| dc_miss_wr | input | 1 | Data miss is a write (1) or a read (0) |
| dc_miss_addr | input | 32 | Byte address of the data miss |
| busy | output | 1 | A snoop/fill sequence is in progress |
| line_addr | output | 27 | Line address for all probes, invalidates, L2 and bus requests |
| dc_probe_vld | output | 1 | Data-cache tag probe strobe |
| dc_probe_hit | input | 1 | Data tag probe hit (same cycle) |
| dc_probe_dirty | input | 1 | Probed data line is modified (same cycle) |
| dc_inval_vld | output | 1 | Invalidate the data-cache line |
| ic_probe_vld | output | 1 | Instruction-cache tag probe strobe |
| ic_probe_hit | input | 1 | Instruction tag probe hit (same cycle) |
| ic_inval_vld | output | 1 | Invalidate the instruction-cache line |
| l2_wb_vld | output | 1 | L2 lookup-and-write of a dirty line |
| l2_wb_hit | input | 1 | L2 held the line and stored it as modified |
| bus_wr_vld | output | 1 | System-bus write request, held until ack |
| bus_wr_ack | input | 1 | Bus write accepted |
| l2_rd_vld | output | 1 | L2 lookup for the instruction fill |
| l2_rd_hit | input | 1 | L2 supplies the fill |
| bus_rd_vld | output | 1 | System-bus read request for the fill, held until ack |
| bus_rd_ack | input | 1 | Bus read data returned |
| ic_fill_done | output | 1 | Instruction fill complete (pulse) |
| ic_fill_from_l2 | output | 1 | Fill source with `ic_fill_done`: 1 = L2, 0 = bus |
| dc_proceed | output | 1 | Data access may now proceed (pulse) |
| dc_proceed_wr | output | 1 | Write flag qualified by `dc_proceed` |

## Verification
The vectors cover the full outcome space of the sibling probe:
- An instruction miss against a data-side miss, a clean hit and a dirty hit. These are told apart by the presence and count of invalidate and writeback strobes.
- For dirty hits, both L2-writeback outcomes. These are told apart by whether a held bus write appears.
- Both fill sources. These are told apart by `ic_fill_from_l2` and by the total busy length.

Data read and write misses are run against hitting and missing instruction tags. Some runs also present hit levels on the tag port that is not being probed, to show those levels are ignored. Directed runs check that two simultaneous requests are handled in order, and that a reset in the middle of a sequence clears it.

// File: rtl/xsnoop_pkg.sv
package xsnoop_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DSNP,      // probe data tags for an instruction miss
    ST_WB_L2,     // try to park the dirty line in L2
    ST_WB_BUS,    // write the dirty line to memory
    ST_DINV,      // drop the data line
    ST_FILL_L2,   // instruction fill lookup in L2
    ST_FILL_BUS,  // instruction fill from memory
    ST_ISNP,      // probe instruction tags for a data miss
    ST_IINV       // drop the instruction line, release data access
  } snp_state_e;

endpackage

// File: rtl/xsnoop_rst_sync.sv
module xsnoop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/xsnoop_req_latch.sv
module xsnoop_req_latch #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              ic_req,
  input  logic [ADDR_W-1:0] ic_addr,
  input  logic              dc_req,
  input  logic              dc_wr,
  input  logic [ADDR_W-1:0] dc_addr,
  output logic              accept,
  output logic              acc_instr,
  output logic [LINE_W-1:0] line_addr,
  output logic              is_wr
);

  logic [LINE_W-1:0] line_d, line_q;
  logic              wr_d, wr_q;
  logic              cap_en;
  logic              unused_offs;

  assign unused_offs = ^{ic_addr[OFF_W-1:0], dc_addr[OFF_W-1:0]};

  // instruction misses win a tie; the data requester keeps holding
  assign accept    = !busy && (ic_req || dc_req);
  assign acc_instr = ic_req;
  assign cap_en    = accept;

  always_comb begin
    line_d = acc_instr ? ic_addr[ADDR_W-1:OFF_W] : dc_addr[ADDR_W-1:OFF_W];
    wr_d   = !acc_instr && dc_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      wr_q   <= 1'b0;
    end else if (cap_en) begin
      line_q <= line_d;
      wr_q   <= wr_d;
    end
  end

  assign line_addr = line_q;
  assign is_wr     = wr_q;

endmodule

// File: rtl/xsnoop_seq.sv
module xsnoop_seq
  import xsnoop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic acc_instr,
  input  logic is_wr,
  input  logic dc_probe_hit,
  input  logic dc_probe_dirty,
  input  logic ic_probe_hit,
  input  logic l2_wb_hit,
  input  logic bus_wr_ack,
  input  logic l2_rd_hit,
  input  logic bus_rd_ack,
  output logic busy,
  output logic dc_probe_vld,
  output logic dc_inval_vld,
  output logic ic_probe_vld,
  output logic ic_inval_vld,
  output logic l2_wb_vld,
  output logic bus_wr_vld,
  output logic l2_rd_vld,
  output logic bus_rd_vld,
  output logic ic_fill_done,
  output logic ic_fill_from_l2,
  output logic dc_proceed,
  output logic dc_proceed_wr
);

  snp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (accept) st_d = acc_instr ? ST_DSNP : ST_ISNP;
      ST_DSNP: begin
        if (!dc_probe_hit)       st_d = ST_FILL_L2;
        else if (dc_probe_dirty) st_d = ST_WB_L2;
        else                     st_d = ST_DINV;
      end
      ST_WB_L2:    st_d = l2_wb_hit ? ST_DINV : ST_WB_BUS;
      ST_WB_BUS:   if (bus_wr_ack) st_d = ST_DINV;
      ST_DINV:     st_d = ST_FILL_L2;
      ST_FILL_L2:  st_d = l2_rd_hit ? ST_IDLE : ST_FILL_BUS;
      ST_FILL_BUS: if (bus_rd_ack) st_d = ST_IDLE;
      ST_ISNP:     st_d = ic_probe_hit ? ST_IINV : ST_IDLE;
      ST_IINV:     st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    busy            = (st_q != ST_IDLE);
    dc_probe_vld    = (st_q == ST_DSNP);
    l2_wb_vld       = (st_q == ST_WB_L2);
    bus_wr_vld      = (st_q == ST_WB_BUS);
    dc_inval_vld    = (st_q == ST_DINV);
    l2_rd_vld       = (st_q == ST_FILL_L2);
    bus_rd_vld      = (st_q == ST_FILL_BUS);
    ic_probe_vld    = (st_q == ST_ISNP);
    ic_inval_vld    = (st_q == ST_IINV);
    ic_fill_from_l2 = (st_q == ST_FILL_L2) && l2_rd_hit;
    ic_fill_done    = ic_fill_from_l2 || ((st_q == ST_FILL_BUS) && bus_rd_ack);
    dc_proceed      = ((st_q == ST_ISNP) && !ic_probe_hit) || (st_q == ST_IINV);
    dc_proceed_wr   = dc_proceed && is_wr;
  end

  // R4: an L2 writeback hit keeps the line off the bus
  a_r4_l2_absorbs_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_wb_vld && l2_wb_hit) |=> !bus_wr_vld);
  // R5: an L2 writeback miss goes to the bus and holds until ack
  a_r5_wb_miss_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_wb_vld && !l2_wb_hit) |=> bus_wr_vld);
  a_r5_bus_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_vld && !bus_wr_ack) |=> bus_wr_vld);
  // R6: a data-probe hit leads to a writeback or straight to invalidate
  a_r6_dhit_acts: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_probe_vld && dc_probe_hit) |=> (l2_wb_vld || dc_inval_vld));
  // R7: an L2 fill miss turns into a bus read
  a_r7_fill_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_rd_vld && !l2_rd_hit) |=> bus_rd_vld);
  // R8: an instruction-probe hit invalidates and releases the data access
  a_r8_ihit_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_probe_vld && ic_probe_hit) |=> (ic_inval_vld && dc_proceed));
  // R10: a data-probe miss goes straight to the fill
  a_r10_dmiss_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_probe_vld && !dc_probe_hit) |=> l2_rd_vld);

endmodule

// File: rtl/l1_xsnoop_ctrl.sv
module l1_xsnoop_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ic_miss_req,
  input  logic [ADDR_W-1:0] ic_miss_addr,
  input  logic              dc_miss_req,
  input  logic              dc_miss_wr,
  input  logic [ADDR_W-1:0] dc_miss_addr,
  output logic              busy,
  output logic [LINE_W-1:0] line_addr,
  output logic              dc_probe_vld,
  input  logic              dc_probe_hit,
  input  logic              dc_probe_dirty,
  output logic              dc_inval_vld,
  output logic              ic_probe_vld,
  input  logic              ic_probe_hit,
  output logic              ic_inval_vld,
  output logic              l2_wb_vld,
  input  logic              l2_wb_hit,
  output logic              bus_wr_vld,
  input  logic              bus_wr_ack,
  output logic              l2_rd_vld,
  input  logic              l2_rd_hit,
  output logic              bus_rd_vld,
  input  logic              bus_rd_ack,
  output logic              ic_fill_done,
  output logic              ic_fill_from_l2,
  output logic              dc_proceed,
  output logic              dc_proceed_wr
);

  logic rst_sync_n;
  logic accept, acc_instr, is_wr;

  xsnoop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xsnoop_req_latch #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .busy      (busy),
    .ic_req    (ic_miss_req),
    .ic_addr   (ic_miss_addr),
    .dc_req    (dc_miss_req),
    .dc_wr     (dc_miss_wr),
    .dc_addr   (dc_miss_addr),
    .accept    (accept),
    .acc_instr (acc_instr),
    .line_addr (line_addr),
    .is_wr     (is_wr)
  );

  xsnoop_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .accept          (accept),
    .acc_instr       (acc_instr),
    .is_wr           (is_wr),
    .dc_probe_hit    (dc_probe_hit),
    .dc_probe_dirty  (dc_probe_dirty),
    .ic_probe_hit    (ic_probe_hit),
    .l2_wb_hit       (l2_wb_hit),
    .bus_wr_ack      (bus_wr_ack),
    .l2_rd_hit       (l2_rd_hit),
    .bus_rd_ack      (bus_rd_ack),
    .busy            (busy),
    .dc_probe_vld    (dc_probe_vld),
    .dc_inval_vld    (dc_inval_vld),
    .ic_probe_vld    (ic_probe_vld),
    .ic_inval_vld    (ic_inval_vld),
    .l2_wb_vld       (l2_wb_vld),
    .bus_wr_vld      (bus_wr_vld),
    .l2_rd_vld       (l2_rd_vld),
    .bus_rd_vld      (bus_rd_vld),
    .ic_fill_done    (ic_fill_done),
    .ic_fill_from_l2 (ic_fill_from_l2),
    .dc_proceed      (dc_proceed),
    .dc_proceed_wr   (dc_proceed_wr)
  );

  // R3: L2 is idle whenever a sibling tag probe runs
  a_r3_no_l2_in_probe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dc_probe_vld || ic_probe_vld) |-> !(l2_wb_vld || l2_rd_vld));
  // R1 / R2: at most one sibling probe at a time
  a_r1_probe_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({dc_probe_vld, ic_probe_vld}));
  // R9: the captured line is frozen for the whole sequence
  a_r9_line_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy)) |-> $stable(line_addr));

endmodule

// File: tb/l1_xsnoop_ctrl_tb.sv
module l1_xsnoop_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ic_miss_req, dc_miss_req, dc_miss_wr;
  logic [31:0] ic_miss_addr, dc_miss_addr;
  logic        busy;
  logic [26:0] line_addr;
  logic        dc_probe_vld, dc_probe_hit, dc_probe_dirty, dc_inval_vld;
  logic        ic_probe_vld, ic_probe_hit, ic_inval_vld;
  logic        l2_wb_vld, l2_wb_hit, bus_wr_vld, bus_wr_ack;
  logic        l2_rd_vld, l2_rd_hit, bus_rd_vld, bus_rd_ack;
  logic        ic_fill_done, ic_fill_from_l2, dc_proceed, dc_proceed_wr;

  always #5 clk = ~clk;

  l1_xsnoop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .ic_miss_req(ic_miss_req), .ic_miss_addr(ic_miss_addr),
    .dc_miss_req(dc_miss_req), .dc_miss_wr(dc_miss_wr), .dc_miss_addr(dc_miss_addr),
    .busy(busy), .line_addr(line_addr),
    .dc_probe_vld(dc_probe_vld), .dc_probe_hit(dc_probe_hit),
    .dc_probe_dirty(dc_probe_dirty), .dc_inval_vld(dc_inval_vld),
    .ic_probe_vld(ic_probe_vld), .ic_probe_hit(ic_probe_hit), .ic_inval_vld(ic_inval_vld),
    .l2_wb_vld(l2_wb_vld), .l2_wb_hit(l2_wb_hit),
    .bus_wr_vld(bus_wr_vld), .bus_wr_ack(bus_wr_ack),
    .l2_rd_vld(l2_rd_vld), .l2_rd_hit(l2_rd_hit),
    .bus_rd_vld(bus_rd_vld), .bus_rd_ack(bus_rd_ack),
    .ic_fill_done(ic_fill_done), .ic_fill_from_l2(ic_fill_from_l2),
    .dc_proceed(dc_proceed), .dc_proceed_wr(dc_proceed_wr)
  );

  typedef struct packed {
    logic        instr, wr, dch, dcd, wbh, rdh, ich;
    logic [31:0] addr;
    logic [3:0]  lat;
    logic [1:0]  n_wb, n_bw, n_br;
    logic        dinv, iinv, src, proc_;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0000_1040, 4'd2,  2'd0,2'd0,2'd0, 1'b0,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_2085, 4'd5,  2'd0,2'd0,2'd3, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0001_00C0, 4'd3,  2'd0,2'd0,2'd0, 1'b1,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0, 32'h0002_0F3F, 4'd4,  2'd1,2'd0,2'd0, 1'b1,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 32'hFFFF_FFE0, 4'd10, 2'd1,2'd3,2'd3, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 32'h8000_0010, 4'd7,  2'd1,2'd3,2'd0, 1'b1,1'b0,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_3000, 4'd1,  2'd0,2'd0,2'd0, 1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0000_3020, 4'd2,  2'd0,2'd0,2'd0, 1'b0,1'b1,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h1234_5678, 4'd1,  2'd0,2'd0,2'd0, 1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 4'd2,  2'd0,2'd0,2'd0, 1'b0,1'b1,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 32'hABCD_EF00, 4'd1,  2'd0,2'd0,2'd0, 1'b0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 32'h0000_4000, 4'd2,  2'd0,2'd0,2'd0, 1'b0,1'b0,1'b1,1'b0}
  };

  int n_tests = 0, n_fail = 0;
  int lat, n_dp, n_ip, n_wb, n_bw, n_br, n_di, n_ii, n_done, n_pr, n_l2p, n_badl;
  logic src_seen, pwr_seen;
  int wcnt, rcnt;

  task automatic chk(input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic any_strobe();
    return dc_probe_vld | ic_probe_vld | dc_inval_vld | ic_inval_vld |
           l2_wb_vld | bus_wr_vld | l2_rd_vld | bus_rd_vld |
           ic_fill_done | dc_proceed;
  endfunction

  // runs from a negedge just after the accepting edge until busy falls
  task automatic observe(input logic [26:0] exp_line);
    lat = 0; n_dp = 0; n_ip = 0; n_wb = 0; n_bw = 0; n_br = 0; n_di = 0;
    n_ii = 0; n_done = 0; n_pr = 0; n_l2p = 0; n_badl = 0;
    src_seen = 1'bx; pwr_seen = 1'bx; wcnt = 0; rcnt = 0;
    while (busy && lat < 64) begin
      if (bus_wr_vld) wcnt++; else wcnt = 0;
      if (bus_rd_vld) rcnt++; else rcnt = 0;
      bus_wr_ack = (wcnt == 3);
      bus_rd_ack = (rcnt == 3);
      #1;
      if (dc_probe_vld) n_dp++;
      if (ic_probe_vld) n_ip++;
      if (l2_wb_vld)    n_wb++;
      if (bus_wr_vld)   n_bw++;
      if (bus_rd_vld)   n_br++;
      if (dc_inval_vld) n_di++;
      if (ic_inval_vld) n_ii++;
      if ((l2_wb_vld | l2_rd_vld) && (dc_probe_vld | ic_probe_vld)) n_l2p++;
      if (any_strobe() && line_addr != exp_line) n_badl++;
      if (ic_fill_done) begin n_done++; src_seen = ic_fill_from_l2; end
      if (dc_proceed)   begin n_pr++;   pwr_seen = dc_proceed_wr;   end
      lat++;
      @(negedge clk);
    end
    bus_wr_ack = 1'b0;
    bus_rd_ack = 1'b0;
  endtask

  task automatic issue(input vec_t v);
    dc_probe_hit = v.dch; dc_probe_dirty = v.dcd; l2_wb_hit = v.wbh;
    l2_rd_hit = v.rdh; ic_probe_hit = v.ich;
    if (v.instr) begin ic_miss_req = 1'b1; ic_miss_addr = v.addr; end
    else begin dc_miss_req = 1'b1; dc_miss_wr = v.wr; dc_miss_addr = v.addr; end
    @(posedge clk); @(negedge clk);
    ic_miss_req = 1'b0; dc_miss_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ic_miss_req = 1'b0; dc_miss_req = 1'b0; dc_miss_wr = 1'b0;
    ic_miss_addr = '0; dc_miss_addr = '0;
    dc_probe_hit = 1'b0; dc_probe_dirty = 1'b0; ic_probe_hit = 1'b0;
    l2_wb_hit = 1'b0; l2_rd_hit = 1'b0; bus_wr_ack = 1'b0; bus_rd_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy, 0, "R11 busy in reset");
    chk(any_strobe(), 0, "R11 strobes in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy, 0, "R11 busy after release");

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      issue(v);
      observe(v.addr[31:5]);
      chk(lat, int'(v.lat), $sformatf("R10 busy cycles vec%0d", i));
      chk(n_dp, v.instr ? 1 : 0, $sformatf("R1 dc probes vec%0d", i));
      chk(n_ip, v.instr ? 0 : 1, $sformatf("R2 ic probes vec%0d", i));
      chk(n_badl, 0, $sformatf("R1 R2 line address vec%0d", i));
      chk(n_l2p, 0, $sformatf("R3 L2 during probe vec%0d", i));
      chk(n_wb, int'(v.n_wb), $sformatf("R4 L2 writebacks vec%0d", i));
      chk(n_bw, int'(v.n_bw), $sformatf("R5 bus write cycles vec%0d", i));
      chk(n_di, int'(v.dinv), $sformatf("R6 dc invalidates vec%0d", i));
      chk(n_br, int'(v.n_br), $sformatf("R7 bus read cycles vec%0d", i));
      chk(n_done, v.instr ? 1 : 0, $sformatf("R7 fill done vec%0d", i));
      if (v.instr) chk(int'(src_seen), int'(v.src), $sformatf("R7 fill source vec%0d", i));
      chk(n_ii, int'(v.iinv), $sformatf("R8 ic invalidates vec%0d", i));
      chk(n_pr, int'(v.proc_), $sformatf("R8 proceed pulses vec%0d", i));
      if (v.proc_) chk(int'(pwr_seen), int'(v.wr), $sformatf("R8 proceed write flag vec%0d", i));
    end

    // R9: simultaneous requests; instruction first, held data miss after
    dc_probe_hit = 1'b0; l2_rd_hit = 1'b0; ic_probe_hit = 1'b1;
    ic_miss_req = 1'b1; ic_miss_addr = 32'h0000_5000;
    dc_miss_req = 1'b1; dc_miss_wr = 1'b1; dc_miss_addr = 32'h0000_6020;
    @(posedge clk); @(negedge clk);
    ic_miss_req = 1'b0;
    observe(27'h0000_5000 >> 5);
    chk(n_dp, 1, "R9 instruction served first");
    chk(n_ip, 0, "R9 data miss ignored while busy");
    chk(lat, 5, "R9 first sequence length");
    chk(n_badl, 0, "R9 line held during first sequence");
    @(posedge clk); @(negedge clk);
    dc_miss_req = 1'b0;
    observe(27'(32'h0000_6020 >> 5));
    chk(n_ip, 1, "R9 held data miss served after idle");
    chk(n_ii, 1, "R8 ic invalidate for held miss");
    chk(int'(pwr_seen), 1, "R8 proceed write flag for held miss");
    chk(n_badl, 0, "R9 second line address");

    // R11: reset in the middle of a long sequence
    issue(VECS[4]);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy, 0, "R11 busy after mid-run reset");
    chk(any_strobe(), 0, "R11 strobes after mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy, 0, "R11 idle after second release");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule